// File: doc/BRIEF.md
# Windowed Frame-Buffer Address Sequencer

This block produces the memory address sequence for one DMA channel that walks a rectangular sub-window of a larger image stored row after row in linear memory. A start pulse captures the window's first address, the byte step per beat, the window width and image width (both in beats) and the total number of beats. Each beat that the channel accepts moves the address forward by one step. When window mode is on, the last beat of each window row also jumps over the part of the image row that lies outside the window, so the following address is the first beat of the next window row.

With window mode off the block is a plain linear incrementer. The block raises a done flag when the programmed number of beats has been consumed and an error flag when a window configuration cannot be walked. It does not move data and has no bus protocol of its own. The address on `addr_o` is the address of the beat currently offered, valid while `busy_o` is high.

Top module: `pip_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `done_o` and `err_o` are 0 and `addr_o` is 0.
- R2: A start pulse with a valid configuration and a nonzero total sets `busy_o` on the next cycle with `addr_o` equal to the sampled start address. It also clears `done_o`, `err_o` and both internal counters.
- R3: With window mode off, every accepted beat (`beat_i` high while busy) that is not the final one adds the step to `addr_o`, and the window width is ignored.
- R4: With window mode on, the accepted beat that completes a window row adds step × (1 + image width − window width) to `addr_o`. Every other non-final beat adds the step.
- R5: The in-row position restarts at zero after each row completes, so beat n of a run sits at start + (⌊n/W⌋·I + n mod W)·step, where W is the window width and I is the image width.
- R6: When the accepted beat count reaches the total, `busy_o` falls and `done_o` rises on the next cycle. `addr_o` keeps the final beat's address, and that final beat never applies a row skip.
- R7: `beat_i` has no effect while the block is not busy: `addr_o`, `done_o` and `err_o` keep their values.
- R8: A start with window mode on and a window width of zero, or an image width smaller than the window width, sets `err_o`, leaves `busy_o` low and produces no addresses.
- R9: A start with a total of zero beats and an otherwise valid configuration sets `done_o` on the next cycle without ever raising `busy_o`.
- R10: The configuration inputs are sampled only on the start pulse. Changing them during a run does not alter the address sequence.
- R11: While busy, a cycle with `beat_i` low leaves `addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; samples the configuration |
| pip_en_i | input | 1 | Window mode enable |
| base_addr_i | input | ADDR_W | Address of the window's first beat |
| step_i | input | ADDR_W | Address increment per beat, in bytes |
| win_width_i | input | CNT_W | Window width in beats |
| img_width_i | input | CNT_W | Image row width in beats |
| total_i | input | CNT_W | Total beats in the run |
| beat_i | input | 1 | Current address accepted by the channel |
| addr_o | output | ADDR_W | Address of the current beat |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run completed |
| err_o | output | 1 | Configuration rejected |

## Verification
The bench builds the block with ADDR_W = 32 and CNT_W = 8. The narrow counter lets random runs use windows of one to six beats and totals of up to forty beats, so many row skips, partial final rows and runs that end exactly on a row boundary occur in a few thousand cycles. Random stalls on `beat_i` and configuration changes in the middle of a run are mixed in. Directed cases cover zero-width windows, images narrower than the window, zero totals and beats offered after completion.

// File: rtl/pip_pkg.sv
package pip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } pip_state_e;
endpackage

// File: rtl/pip_beat_ctr.sv
module pip_beat_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] total_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = ((cnt_q + CNT_W'(1)) == total_i);
endmodule

// File: rtl/pip_row_ctr.sv
module pip_row_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             at_edge;

  assign at_edge = ((pos_q + CNT_W'(1)) == width_i);

  always_comb begin
    pos_d = pos_q;
    if (clr_i)      pos_d = '0;
    else if (adv_i) pos_d = at_edge ? '0 : pos_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign wrap_o = at_edge;

  // R5: the in-row position always stays inside the window while advancing
  assert_row_in_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (pos_q < width_i));
endmodule

// File: rtl/pip_addr_reg.sv
module pip_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              adv_i,
  input  logic              skip_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic [ADDR_W-1:0] hole_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] extra;

  assign extra = skip_i ? hole_i : '0;

  always_comb begin
    addr_d = addr_q;
    if (load_i)     addr_d = load_val_i;
    else if (adv_i) addr_d = addr_q + step_i + extra;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/pip_addr_gen.sv
module pip_addr_gen
  import pip_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pip_en_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] step_i,
  input  logic [CNT_W-1:0]  win_width_i,
  input  logic [CNT_W-1:0]  img_width_i,
  input  logic [CNT_W-1:0]  total_i,
  input  logic              beat_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  pip_state_e        state_q, state_d;
  logic [ADDR_W-1:0] step_q, hole_q, hole_d;
  logic [CNT_W-1:0]  win_q, total_q;
  logic              pip_q;
  logic              cfg_bad, adv, last, row_wrap;
  logic [CNT_W-1:0]  beat_cnt;

  assign cfg_bad = pip_en_i && ((win_width_i == '0) || (img_width_i < win_width_i));
  assign adv     = (state_q == ST_RUN) && beat_i && !start_i;
  assign hole_d  = pip_en_i ? ADDR_W'(img_width_i - win_width_i) * step_i : '0;

  // next-state logic
  always_comb begin
    state_d = state_q;
    if (start_i) begin
      if (cfg_bad)               state_d = ST_ERR;
      else if (total_i == '0)    state_d = ST_DONE;
      else                       state_d = ST_RUN;
    end else if (adv && last) begin
      state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // configuration captured only on start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= '0;
      hole_q  <= '0;
      win_q   <= '0;
      total_q <= '0;
      pip_q   <= 1'b0;
    end else if (start_i) begin
      step_q  <= step_i;
      hole_q  <= hole_d;
      win_q   <= win_width_i;
      total_q <= total_i;
      pip_q   <= pip_en_i;
    end
  end

  pip_beat_ctr #(.CNT_W(CNT_W)) i_beat_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .adv_i   (adv),
    .total_i (total_q),
    .cnt_o   (beat_cnt),
    .last_o  (last)
  );

  pip_row_ctr #(.CNT_W(CNT_W)) i_row_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_i),
    .adv_i   (adv && pip_q),
    .width_i (win_q),
    .wrap_o  (row_wrap)
  );

  pip_addr_reg #(.ADDR_W(ADDR_W)) i_addr_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i),
    .load_val_i (base_addr_i),
    .adv_i      (adv && !last),
    .skip_i     (row_wrap && pip_q),
    .step_i     (step_q),
    .hole_i     (hole_q),
    .addr_o     (addr_o)
  );

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = (state_q == ST_ERR);

  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cfg_bad && (total_i != '0)) |=> (busy_o && (addr_o == $past(base_addr_i))));

  assert_plain_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !last && !pip_q) |=> (addr_o == $past(addr_o) + $past(step_q)));

  assert_final_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && last) |=> (done_o && !busy_o && $stable(addr_o)));

  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (beat_cnt < total_q));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(addr_o));

  assert_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && pip_en_i && (win_width_i == '0)) |=> (err_o && !busy_o));

  assert_stall_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !beat_i && !start_i) |=> $stable(addr_o));
endmodule

// File: tb/test_pip_addr_gen.sv
module test_pip_addr_gen;
  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          pip_en = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] step = '0;
  logic [CW-1:0] win = '0;
  logic [CW-1:0] img = '0;
  logic [CW-1:0] total = '0;
  logic          beat = 1'b0;
  logic [AW-1:0] addr;
  logic          busy, done, err;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pip_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) i_pip_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pip_en_i(pip_en),
    .base_addr_i(base), .step_i(step), .win_width_i(win), .img_width_i(img),
    .total_i(total), .beat_i(beat), .addr_o(addr), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  function automatic logic [31:0] exp_addr(logic [31:0] b, logic [31:0] s,
                                           int w, int im, bit p, int n);
    if (p) return b + 32'((n / w) * im + (n % w)) * s;
    return b + 32'(n) * s;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic do_start(logic [31:0] b, logic [31:0] s, int w, int im, int t, bit p);
    @(negedge clk);
    base = b; step = s; win = CW'(w); img = CW'(im); total = CW'(t); pip_en = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // full run with random stalls; optional config scrambling (R10)
  task automatic run(logic [31:0] b, logic [31:0] s, int w, int im, int t, bit p, bit scramble);
    do_start(b, s, w, im, t, p);
    if (scramble) begin
      base = $urandom; step = $urandom; win = CW'($urandom); img = CW'($urandom);
      total = CW'($urandom); pip_en = ~p;
    end
    chk(busy && !done && !err, "R2 busy after start", {29'd0, busy, done, err}, 32'd4);
    for (int n = 0; n < t; n++) begin
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        chk(addr == exp_addr(b, s, w, im, p, n), "R11 stall hold", addr, exp_addr(b, s, w, im, p, n));
      end
      chk(busy, "R6 busy mid-run", {31'd0, busy}, 32'd1);
      chk(addr == exp_addr(b, s, w, im, p, n), p ? "R4 R5 window addr" : "R3 linear addr",
          addr, exp_addr(b, s, w, im, p, n));
      beat = 1'b1;
      @(negedge clk);
      beat = 1'b0;
    end
    chk(done && !busy, "R6 done after total", {30'd0, busy, done}, 32'd1);
    chk(addr == exp_addr(b, s, w, im, p, t - 1), "R6 final addr held", addr,
        exp_addr(b, s, w, im, p, t - 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && addr == '0, "R1 reset state", addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && addr == '0, "R1 after release", addr, 32'd0);

    // R3: linear mode, width ignored (zero)
    run(32'h1000, 32'd4, 0, 0, 5, 1'b0, 1'b0);
    // R4/R5: 3-wide window in 8-wide image, ends on row boundary
    run(32'h2000, 32'd2, 3, 8, 9, 1'b1, 1'b0);
    // window equals image: no hole
    run(32'h3000, 32'd4, 4, 4, 10, 1'b1, 1'b0);
    // single-beat window
    run(32'h4000, 32'd1, 1, 5, 6, 1'b1, 1'b1);

    // R7: beats after done are ignored
    beat = 1'b1;
    repeat (3) @(negedge clk);
    beat = 1'b0;
    chk(done && !busy && addr == exp_addr(32'h4000, 1, 1, 5, 1, 5), "R7 idle beats ignored",
        addr, exp_addr(32'h4000, 1, 1, 5, 1, 5));

    // R8: zero-width window rejected
    do_start(32'h5000, 32'd4, 0, 8, 4, 1'b1);
    chk(err && !busy && !done, "R8 zero width", {29'd0, busy, done, err}, 32'd1);
    beat = 1'b1;
    repeat (2) @(negedge clk);
    beat = 1'b0;
    chk(err && !busy && addr == 32'h5000, "R7 R8 no addresses after reject", addr, 32'h5000);
    // R8: image narrower than window
    do_start(32'h6000, 32'd4, 6, 3, 4, 1'b1);
    chk(err && !busy, "R8 image narrower", {29'd0, busy, done, err}, 32'd1);

    // R9: zero total
    do_start(32'h7000, 32'd4, 2, 4, 0, 1'b1);
    chk(done && !busy && !err, "R9 zero total", {29'd0, busy, done, err}, 32'd2);
    // R2: start clears err/done
    run(32'h8000, 32'd8, 2, 7, 5, 1'b1, 1'b0);

    // random runs, R10 scramble on some
    for (int k = 0; k < 40; k++) begin
      int w, im, t;
      bit p;
      logic [31:0] s;
      w  = int'($urandom_range(6, 1));
      im = w + int'($urandom_range(5));
      t  = int'($urandom_range(40, 1));
      p  = 1'($urandom_range(1));
      case ($urandom_range(3))
        0: s = 32'd1;
        1: s = 32'd2;
        2: s = 32'd4;
        default: s = 32'd8;
      endcase
      run($urandom & 32'hFFFF_FFF0, s, w, im, t, p, k[0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule